// File: doc/BRIEF.md
# Bank-Switched RAM Address Decoder

This block sits on the 16-bit external data bus of an 8-bit microcontroller. It turns each bus address into one chip select: a large 512 KB SRAM, an Ethernet controller, or the block's own bank register. It also drives the 19-bit SRAM address. The lower half of the CPU space reaches a fixed 32 KB of the SRAM. A 16 KB window above it shows any one of 30 further SRAM banks, and software picks that bank by writing a small register near the top of the address space. At any moment the CPU can see 48 KB of the 512 KB.

The two SRAM banks that back the fixed region can never be picked for the window, so the two views of the RAM never alias. The bottom of the fixed region is covered by the CPU's own internal registers and RAM. Accesses there stay inside the CPU, so the decoder asserts nothing for them. An empty gap above the Ethernet space selects no device. When the CPU reads from that gap, the block drives an idle byte onto the bus.

Top module: `bank_window_decoder`

## Requirements
- R1: A strobed access (read or write) to 0x1100–0x7FFF asserts `sram_cs` alone, and `sram_addr` equals the CPU address zero-extended to 19 bits.
- R2: Addresses 0x0000–0x10FF belong to the CPU's internal resources, and no select is asserted for them, even with a strobe.
- R3: A strobed access to 0x8000–0xBFFF asserts `sram_cs`, and `sram_addr` is {bank+2, cpu_addr[13:0]}, with the bank number in the upper 5 bits.
- R4: A strobed access to 0xC000–0xCFFF asserts `eth_cs` alone, and `sram_cs` stays low.
- R5: 0xD000–0xFEFF asserts no select, and a read there drives `cpu_rdata` = 0xFF with `rdata_oe` high.
- R6: 0xFF00–0xFFFF asserts `reg_sel`. A write there with data 0–29 loads the bank register at that clock edge, and the next window access uses the new bank.
- R7: A write to the register space with data 30–255 is ignored, and the bank register keeps its value.
- R8: A read from 0xFF00–0xFFFF returns the current bank number on `cpu_rdata`, zero-extended, with `rdata_oe` high.
- R9: Reset clears the bank register to 0.
- R10: Selects are asserted only while `cpu_rd` or `cpu_wr` is high, and at most one of `sram_cs`, `eth_cs` and `reg_sel` is high at a time.
- R11: `sram_addr` is 0 for any address outside 0x0000–0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_wdata | input | 8 | Write data from the CPU |
| cpu_rdata | output | 8 | Bank number or idle byte for reads this block answers |
| rdata_oe | output | 1 | High when this block drives `cpu_rdata` |
| sram_cs | output | 1 | SRAM chip select, active high |
| eth_cs | output | 1 | Ethernet controller select, active high |
| reg_sel | output | 1 | Bank register select, active high |
| sram_addr | output | 19 | SRAM address |

## Verification
The bench probes both edges of every region. A decoder that was off by one at 0x10FF/0x1100, 0xBFFF/0xC000 or 0xFEFF/0xFF00 would select the wrong device or no device at all at one of those edges. It loads banks 5 and 29 and then checks the window address. A design that forgot the offset of two would alias the fixed RAM, and one that overflowed the bank field would wrap at bank 29. It writes 30 and 255 and then reads the register back. A design that did not clamp these writes would point the window at a bank it must never use, or at a bank that does not exist.

// File: rtl/bank_window_decoder.sv
module bank_window_decoder #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SRAM_AW   = 19,
  parameter int WIN_AW    = 14,
  parameter int NUM_BANKS = 30,
  parameter logic [15:0] INT_TOP  = 16'h10FF,
  parameter logic [15:0] ETH_BASE = 16'hC000,
  parameter logic [15:0] ETH_TOP  = 16'hCFFF,
  parameter logic [15:0] REG_BASE = 16'hFF00,
  parameter logic [7:0]  IDLE_VAL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               rdata_oe,
  output logic               sram_cs,
  output logic               eth_cs,
  output logic               reg_sel,
  output logic [SRAM_AW-1:0] sram_addr
);
  localparam int BANK_W = SRAM_AW - WIN_AW;
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] WIN_TOP  = WIN_BASE + (ADDR_W'(1) << WIN_AW) - ADDR_W'(1);
  localparam int FIXED_BANKS = 1 << (ADDR_W - 1 - WIN_AW);

  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] win_bank;
  logic strobe, in_int, in_fixed, in_win, in_eth, in_reg, in_gap;

  assign strobe   = cpu_rd | cpu_wr;
  assign in_int   = cpu_addr <= ADDR_W'(INT_TOP);
  assign in_fixed = cpu_addr < WIN_BASE;
  assign in_win   = (cpu_addr >= WIN_BASE) && (cpu_addr <= WIN_TOP);
  assign in_eth   = (cpu_addr >= ADDR_W'(ETH_BASE)) && (cpu_addr <= ADDR_W'(ETH_TOP));
  assign in_reg   = cpu_addr >= ADDR_W'(REG_BASE);
  assign in_gap   = !in_fixed && !in_win && !in_eth && !in_reg;

  assign sram_cs  = strobe && ((in_fixed && !in_int) || in_win);
  assign eth_cs   = strobe && in_eth;
  assign reg_sel  = strobe && in_reg;

  assign win_bank = bank_q + BANK_W'(FIXED_BANKS);

  always_comb begin
    if (in_fixed)    sram_addr = SRAM_AW'(cpu_addr);
    else if (in_win) sram_addr = {win_bank, cpu_addr[WIN_AW-1:0]};
    else             sram_addr = '0;
  end

  assign rdata_oe  = cpu_rd && (in_reg || in_gap);
  assign cpu_rdata = in_reg ? DATA_W'(bank_q) : (in_gap ? DATA_W'(IDLE_VAL) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bank_q <= '0;
    else if (cpu_wr && in_reg && (cpu_wdata < DATA_W'(NUM_BANKS)))
      bank_q <= cpu_wdata[BANK_W-1:0];
  end
endmodule

module bank_window_decoder_chk #(
  parameter int SRAM_AW   = 19,
  parameter int WIN_AW    = 14,
  parameter int NUM_BANKS = 30
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [15:0]                cpu_addr,
  input logic                       cpu_rd,
  input logic                       cpu_wr,
  input logic [7:0]                 cpu_wdata,
  input logic                       sram_cs,
  input logic                       eth_cs,
  input logic                       reg_sel,
  input logic [SRAM_AW-1:0]         sram_addr,
  input logic [SRAM_AW-WIN_AW-1:0]  bank
);
  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_cs, eth_cs, reg_sel}));
  assert_no_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |-> !(sram_cs || eth_cs || reg_sel));
  assert_internal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr <= 16'h10FF) |-> !sram_cs);
  assert_window_skips_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_cs && cpu_addr[15:14] == 2'b10) |-> (sram_addr[SRAM_AW-1:WIN_AW] >= 2));
  assert_eth_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eth_cs |-> (cpu_addr[15:12] == 4'hC));
  assert_bank_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && cpu_wr && cpu_wdata < 8'(NUM_BANKS)) |=> (8'(bank) == $past(cpu_wdata)));
  assert_bad_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && cpu_wr && cpu_wdata >= 8'(NUM_BANKS)) |=> $stable(bank));
  assert_bank_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bank) < NUM_BANKS));
endmodule

bind bank_window_decoder bank_window_decoder_chk #(
  .SRAM_AW(SRAM_AW), .WIN_AW(WIN_AW), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .sram_cs(sram_cs),
  .eth_cs(eth_cs), .reg_sel(reg_sel), .sram_addr(sram_addr), .bank(bank_q)
);

// File: tb/bank_window_decoder_bench.sv
module bank_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        rdata_oe, sram_cs, eth_cs, reg_sel;
  logic [18:0] sram_addr;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bank_window_decoder u_bank_window_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rdata_oe(rdata_oe), .sram_cs(sram_cs), .eth_cs(eth_cs),
    .reg_sel(reg_sel), .sram_addr(sram_addr)
  );

  // {addr, rd, wr, sram_cs, eth_cs, reg_sel, sram_addr} with bank 0
  localparam logic [39:0] VEC [12] = '{
    {16'h0000, 2'b10, 3'b000, 19'h00000},  // R2
    {16'h10FF, 2'b01, 3'b000, 19'h010FF},  // R2
    {16'h1100, 2'b10, 3'b100, 19'h01100},  // R1
    {16'h7FFF, 2'b01, 3'b100, 19'h07FFF},  // R1
    {16'h8000, 2'b10, 3'b100, 19'h08000},  // R3
    {16'hBFFF, 2'b01, 3'b100, 19'h0BFFF},  // R3
    {16'hC000, 2'b10, 3'b010, 19'h00000},  // R4 R11
    {16'hCFFF, 2'b01, 3'b010, 19'h00000},  // R4
    {16'hD000, 2'b10, 3'b000, 19'h00000},  // R5
    {16'hFEFF, 2'b01, 3'b000, 19'h00000},  // R5
    {16'h4000, 2'b00, 3'b000, 19'h04000},  // R10
    {16'hC800, 2'b00, 3'b000, 19'h00000}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    #1;
  endtask

  task automatic reg_write(input logic [7:0] d);
    drive(16'hFF00, 1'b0, 1'b1, d);
    chk("R6 reg_sel on write", 32'(reg_sel), 1);
    @(posedge clk);
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(16'hFF00, 1'b1, 1'b0, 8'h00);
    chk("R9 bank after reset", 32'(cpu_rdata), 0);
    chk("R8 reg read oe", 32'(rdata_oe), 1);

    foreach (VEC[i]) begin
      drive(VEC[i][39:24], VEC[i][23], VEC[i][22], 8'h00);
      chk("R1-table selects", {29'd0, sram_cs, eth_cs, reg_sel}, 32'(VEC[i][21:19]));
      chk("R11 table sram_addr", 32'(sram_addr), 32'(VEC[i][18:0]));
    end

    drive(16'hD000, 1'b1, 1'b0, 8'h00);
    chk("R5 idle byte", 32'(cpu_rdata), 32'hFF);
    chk("R5 idle oe", 32'(rdata_oe), 1);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    chk("R5 no oe for sram", 32'(rdata_oe), 0);

    reg_write(8'd5);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    chk("R6 bank5 window", 32'(sram_addr), (7 << 14));
    drive(16'h1234, 1'b1, 1'b0, 8'h00);
    chk("R1 fixed unchanged by bank", 32'(sram_addr), 32'h1234);

    reg_write(8'd29);
    drive(16'hB123, 1'b0, 1'b1, 8'h00);
    chk("R3 bank29 window", 32'(sram_addr), (31 << 14) | 32'h3123);

    reg_write(8'd30);
    drive(16'hFFFF, 1'b1, 1'b0, 8'h00);
    chk("R7 write 30 ignored", 32'(cpu_rdata), 29);
    reg_write(8'd255);
    drive(16'hFF80, 1'b1, 1'b0, 8'h00);
    chk("R7 write 255 ignored", 32'(cpu_rdata), 29);
    chk("R8 reg_sel read", 32'(reg_sel), 1);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    chk("R7 window still bank29", 32'(sram_addr), (31 << 14));

    reg_write(8'd0);
    drive(16'h8001, 1'b1, 1'b0, 8'h00);
    chk("R6 bank0 window", 32'(sram_addr), (2 << 14) | 1);

    reg_write(8'd12);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(16'hFF00, 1'b1, 1'b0, 8'h00);
    chk("R9 reset clears bank", 32'(cpu_rdata), 0);
    finish_run();
  end
endmodule